// File: doc/BRIEF.md
# Quad Supply Channel Status Logic

This block is the digital decision stage of a four-channel power-supply monitor. Analog comparators outside the block report, for each channel, whether the supply sits above its under-voltage trip point, and for channels 3 and 4 whether the input sits above an over-voltage trip point. The block brings these results and the per-channel enables into the clock domain, rejects short pulses, and turns them into four status levels. A falling supply is reported after a short fixed delay. A supply that recovers, or a channel that is switched on, is reported valid only after that channel's release delay has elapsed.

A static mode input pairs the channels. In under-voltage mode all four channels are independent. In over-voltage mode channel 3 guards the upper limit of the supply on channel 1, and channel 4 does the same for channel 2. Each merged result appears on output 1 or 2, and outputs 3 and 4 fall idle. A second static input flips the sense of outputs 3 and 4. The block also decodes a two-bit threshold select into one nominal-threshold index per channel, for use by the analog trim logic.

Top module: `stsup_quad`

## Requirements
- R1: A channel whose effective enable is low holds its status at 0 before inversion, and comparator activity on that channel leaves its output unchanged.
- R2: With mode input 0, once inputs have settled, status bit k is 1 exactly when enable k and under-voltage-ok k are both 1 (bits 2 and 3 are subject to R5).
- R3: With mode input 1, status bit 0 settles to en[0] & en[2] & uv_ok[0] & ~ov_hi[0], and status bit 1 settles to en[1] & en[3] & uv_ok[1] & ~ov_hi[1].
- R4: With mode input 1, channels 3 and 4 are held inactive (0 before inversion), whatever their enables, comparator bits and release delays.
- R5: Invert input 1 flips status bits 2 and 3 in both modes, including when disabled or inactive; with mode 1 and invert 1 both bits read 1.
- R6: When a comparator result that makes a channel invalid changes just before clock edge 0, the status falls at edge 1+UV_FILT+FALL_DLY (13 with defaults).
- R7: When a channel's comparator result becomes valid just before edge 0 and the channel is enabled, the status rises at edge 1+UV_FILT+D, where D is that channel's effective release delay.
- R8: An enable falling just before edge 0 clears the status at edge 2+EN_FILT (5 with defaults), even when a comparator fall starts in the same cycle; an enable rising just before edge 0 with valid inputs raises it at edge 1+EN_FILT+D.
- R9: A comparator pulse shorter than UV_FILT cycles (8) and an enable pulse shorter than EN_FILT cycles (3) leave the status unchanged; a comparator pulse of exactly UV_FILT cycles passes.
- R10: Writing dly_we_i[k] with a nonzero dly_wdata_i sets channel k's release delay to that many cycles; writing 0 restores the default DLY_DEFAULT (20), which is also the delay after reset.
- R11: thr_idx_o holds one 3-bit field per channel, channel k at bits 3k+2..3k, coded 0=3.3 V, 1=2.5 V, 2=1.8 V, 3=1.5 V, 4=1.2 V, 5=1.0 V, 7=adjustable. Select 00 gives 0,1,2,3; 01 gives 0,2,3,4; 10 gives 0,3,4,5; 11 gives 7 on every channel (channel order 1 to 4).
- R12: While rst_n is low, every status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_ok_i | input | 4 | Per-channel comparator: 1 when supply is above its under-voltage trip point |
| ov_hi_i | input | 2 | Comparator on channels 3 and 4: 1 when above the over-voltage trip point |
| en_i | input | 4 | Per-channel enable, active high |
| ov_mode_i | input | 1 | 1 pairs channels 3/4 with 1/2 as over-voltage guards |
| invert_i | input | 1 | 1 inverts status bits 2 and 3 |
| thr_sel_i | input | 2 | Threshold set select |
| dly_we_i | input | 4 | Per-channel release-delay write strobe |
| dly_wdata_i | input | DLY_W | Release delay value in cycles (0 means default) |
| status_o | output | 4 | Channel status levels |
| thr_idx_o | output | 12 | Nominal threshold index, 3 bits per channel |

## Verification
The interesting collision is an enable drop landing in the same cycle as a comparator fall on the same channel: the comparator path would clear the output at edge 13 while the enable path clears it at edge 5. The bench drives both changes on the same falling clock edge and requires the output to still be high after edge 4 and low after edge 5, proving the faster enable path wins and the pending fall count is discarded. The second overlap, a release-delay rewrite versus a running rise count, is judged through the measured rise edge after each write.

// File: rtl/stsup_pkg.sv
package stsup_pkg;

    localparam int unsigned NCH   = 4;
    localparam int unsigned NPAIR = 2;
    localparam int unsigned THR_W = 3;

    localparam logic [THR_W-1:0] THR_ADJ = 3'd7;

    // Nominal ladder index: 0=3.3V 1=2.5V 2=1.8V 3=1.5V 4=1.2V 5=1.0V, 7=adjustable.
    // Channel 1 always sits at the top rung; higher channels step down with the select.
    function automatic logic [THR_W-1:0] thr_code(input int unsigned ch, input logic [1:0] sel);
        if (sel == 2'b11) begin
            return THR_ADJ;
        end
        if (ch == 0) begin
            return '0;
        end
        return THR_W'(ch) + {1'b0, sel};
    endfunction

endpackage

// File: rtl/stsup_sync.sv
module stsup_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/stsup_deglitch.sv
module stsup_deglitch #(
    parameter int unsigned HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    localparam int unsigned CW = $clog2(HOLD) + 1;

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    // The filtered level follows the input only after HOLD consecutive
    // cycles of disagreement; any agreement restarts the count.
    always_comb begin
        st_d = st_q;
        if (d_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(HOLD - 1)) begin
            st_d.lvl = d_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.lvl;

endmodule

// File: rtl/stsup_chan_timer.sv
module stsup_chan_timer #(
    parameter int unsigned FALL_DLY = 4,
    parameter int unsigned DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cond_i,
    input  logic [DW-1:0] dly_i,
    output logic          out_o
);

    localparam int unsigned FW = $clog2(FALL_DLY) + 1;
    localparam int unsigned CW = (DW > FW) ? DW : FW;

    typedef struct packed {
        logic          out;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t       st_d, st_q;
    logic [CW-1:0] rise_lim;

    assign rise_lim = CW'(dly_i) - CW'(1);

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.out = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.out == cond_i) begin
            st_d.cnt = '0;
        end else if (!cond_i) begin
            if (st_q.cnt == CW'(FALL_DLY - 1)) begin
                st_d.out = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            if (st_q.cnt >= rise_lim) begin
                st_d.out = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

endmodule

// File: rtl/stsup_quad.sv
module stsup_quad
    import stsup_pkg::*;
#(
    parameter int unsigned UV_FILT     = 8,
    parameter int unsigned EN_FILT     = 3,
    parameter int unsigned FALL_DLY    = 4,
    parameter int unsigned DLY_W       = 8,
    parameter int unsigned DLY_DEFAULT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       uv_ok_i,
    input  logic [1:0]       ov_hi_i,
    input  logic [3:0]       en_i,
    input  logic             ov_mode_i,
    input  logic             invert_i,
    input  logic [1:0]       thr_sel_i,
    input  logic [3:0]       dly_we_i,
    input  logic [DLY_W-1:0] dly_wdata_i,
    output logic [3:0]       status_o,
    output logic [11:0]      thr_idx_o
);

    localparam int unsigned SYNC_W = 2 * NCH + NPAIR + 4;

    typedef struct packed {
        logic [NCH-1:0][DLY_W-1:0] dly;
    } cfg_st_t;

    logic [SYNC_W-1:0]          raw_bus, syn_bus;
    logic [NCH-1:0]             uv_s, en_s, uv_f, en_f;
    logic [NPAIR-1:0]           ov_s, ov_f;
    logic                       mode_s, inv_s;
    logic [1:0]                 thr_s;
    logic [NCH-1:0]             chan_en, chan_cond, chan_out;
    logic [NCH-1:0][DLY_W-1:0]  eff_dly;
    cfg_st_t                    st_d, st_q;

    assign raw_bus = {thr_sel_i, invert_i, ov_mode_i, en_i, ov_hi_i, uv_ok_i};

    stsup_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (syn_bus)
    );

    assign {thr_s, inv_s, mode_s, en_s, ov_s, uv_s} = syn_bus;

    for (genvar k = 0; k < NCH; k++) begin : g_flt
        stsup_deglitch #(.HOLD(UV_FILT)) u_uv_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (uv_s[k]),
            .q_o   (uv_f[k])
        );
        stsup_deglitch #(.HOLD(EN_FILT)) u_en_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (en_s[k]),
            .q_o   (en_f[k])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_ovf
        stsup_deglitch #(.HOLD(UV_FILT)) u_ov_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (ov_s[p]),
            .q_o   (ov_f[p])
        );
    end

    // Release-delay registers.
    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCH; k++) begin
            if (dly_we_i[k]) begin
                st_d.dly[k] = dly_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            eff_dly[k] = (st_q.dly[k] == '0) ? DLY_W'(DLY_DEFAULT) : st_q.dly[k];
        end
    end

    // Channel pairing by mode.
    always_comb begin
        if (!mode_s) begin
            chan_en   = en_f;
            chan_cond = uv_f;
        end else begin
            chan_en   = '0;
            chan_cond = '0;
            for (int p = 0; p < NPAIR; p++) begin
                chan_en[p]   = en_f[p] & en_f[p+NPAIR];
                chan_cond[p] = uv_f[p] & ~ov_f[p];
            end
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_tmr
        stsup_chan_timer #(.FALL_DLY(FALL_DLY), .DW(DLY_W)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (chan_en[k]),
            .cond_i (chan_cond[k]),
            .dly_i  (eff_dly[k]),
            .out_o  (chan_out[k])
        );
    end

    assign status_o[1:0] = chan_out[1:0];
    assign status_o[3:2] = chan_out[3:2] ^ {2{inv_s}};

    for (genvar k = 0; k < NCH; k++) begin : g_thr
        assign thr_idx_o[THR_W*k +: THR_W] = thr_code(k, thr_s);
    end

endmodule

// File: rtl/stsup_quad_chk.sv
module stsup_quad_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  chan_en,
    input logic [3:0]  chan_cond,
    input logic [3:0]  chan_out,
    input logic [3:0]  en_f,
    input logic        mode_s,
    input logic        inv_s,
    input logic [1:0]  thr_s,
    input logic [3:0]  status_o,
    input logic [11:0] thr_idx_o
);

    for (genvar k = 0; k < 4; k++) begin : g_ch
        assert_disabled_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[k] |=> !chan_out[k])
            else $error("channel %0d high while disabled", k);

        assert_hold_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
            chan_en[k] && chan_out[k] && chan_cond[k] |=> chan_out[k])
            else $error("channel %0d dropped while valid", k);

        assert_rise_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_out[k]) |-> $past(chan_cond[k] && chan_en[k]))
            else $error("channel %0d rose without valid input", k);
    end

    for (genvar p = 0; p < 2; p++) begin : g_pair
        assert_partner_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
            mode_s && !en_f[p+2] |=> !chan_out[p])
            else $error("pair %0d valid with partner disabled", p);
    end

    assert_upper_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s |=> !chan_out[2] && !chan_out[3])
        else $error("upper channels active in paired mode");

    assert_inverted_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s && $past(mode_s) |-> status_o[3:2] == {2{inv_s}})
        else $error("upper status not at idle level");

    assert_thr_adj_R11: assert property (@(posedge clk) disable iff (!rst_n)
        thr_s == 2'b11 |-> thr_idx_o == 12'hFFF)
        else $error("adjustable select not decoded");

    assert_thr_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        thr_s != 2'b11 |-> thr_idx_o[2:0] == 3'd0)
        else $error("channel 1 threshold not at top rung");

    always_comb begin
        if (!rst_n) begin
            assert_reset_low_R12: assert (status_o == 4'b0000 || $isunknown(status_o))
                else $error("status nonzero in reset");
        end
    end

endmodule

bind stsup_quad stsup_quad_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .chan_cond (chan_cond),
    .chan_out  (chan_out),
    .en_f      (en_f),
    .mode_s    (mode_s),
    .inv_s     (inv_s),
    .thr_s     (thr_s),
    .status_o  (status_o),
    .thr_idx_o (thr_idx_o)
);

// File: tb/stsup_quad_tb.sv
module stsup_quad_tb_top;

    localparam int UV_FILT  = 8;
    localparam int EN_FILT  = 3;
    localparam int FALL_DLY = 4;
    localparam int DLY_DEF  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  uv = '0;
    logic [1:0]  ov = '0;
    logic [3:0]  en = '0;
    logic        mode = 1'b0;
    logic        inv = 1'b0;
    logic [1:0]  thr = '0;
    logic [3:0]  we = '0;
    logic [7:0]  wd = '0;
    logic [3:0]  status;
    logic [11:0] thr_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    stsup_quad dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .uv_ok_i     (uv),
        .ov_hi_i     (ov),
        .en_i        (en),
        .ov_mode_i   (mode),
        .invert_i    (inv),
        .thr_sel_i   (thr),
        .dly_we_i    (we),
        .dly_wdata_i (wd),
        .status_o    (status),
        .thr_idx_o   (thr_idx)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_status(input logic [3:0] e, input logic [3:0] u,
                                               input logic [1:0] o, input logic m, input logic iv);
        logic [3:0] r;
        if (!m) begin
            r = e & u;
        end else begin
            r[0] = e[0] & e[2] & u[0] & ~o[0];
            r[1] = e[1] & e[3] & u[1] & ~o[1];
            r[3:2] = 2'b00;
        end
        r[3:2] = r[3:2] ^ {2{iv}};
        return r;
    endfunction

    function automatic logic [11:0] exp_thr(input logic [1:0] s);
        case (s)
            2'b00:   return {3'd3, 3'd2, 3'd1, 3'd0};
            2'b01:   return {3'd4, 3'd3, 3'd2, 3'd0};
            2'b10:   return {3'd5, 3'd4, 3'd3, 3'd0};
            default: return {3'd7, 3'd7, 3'd7, 3'd7};
        endcase
    endfunction

    task automatic write_dly(input int ch, input logic [7:0] v);
        wd = v;
        we = 4'b0001 << ch;
        step(1);
        we = '0;
    endtask

    // Holds a bit of status for n cycles, one check for the whole window.
    task automatic hold_chk(input string req, input int bitn, input logic v, input int n);
        bit bad = 1'b0;
        logic seen = v;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (status[bitn] !== v) begin
                bad = 1'b1;
                seen = status[bitn];
            end
        end
        chk(req, {11'd0, bad ? seen : v}, {11'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        step(3);
        chk("R12 reset", {8'd0, status}, 12'h000);
        rst_n = 1'b1;
        step(5);
        chk("R1 idle after reset", {8'd0, status}, 12'h000);

        // R11 threshold decode
        for (int s = 0; s < 4; s++) begin
            thr = 2'(s);
            step(4);
            chk("R11 thr index", thr_idx, exp_thr(2'(s)));
        end

        // R2 independent channels
        en = 4'hF; uv = 4'hF;
        step(50);
        chk("R2 all valid", {8'd0, status}, 12'h00F);

        // R6 fall latency, R7 rise latency
        uv[0] = 1'b0;
        step(1 + UV_FILT + FALL_DLY);
        chk("R6 before fall", {11'd0, status[0]}, 12'd1);
        step(1);
        chk("R6 after fall", {11'd0, status[0]}, 12'd0);
        step(10);
        uv[0] = 1'b1;
        step(1 + UV_FILT + DLY_DEF);
        chk("R7 before rise", {11'd0, status[0]}, 12'd0);
        step(1);
        chk("R7 after rise", {11'd0, status[0]}, 12'd1);

        // R8 enable paths
        en[1] = 1'b0;
        step(2 + EN_FILT);
        chk("R8 before en drop", {11'd0, status[1]}, 12'd1);
        step(1);
        chk("R8 after en drop", {11'd0, status[1]}, 12'd0);
        step(10);
        en[1] = 1'b1;
        step(1 + EN_FILT + DLY_DEF);
        chk("R8 before en rise", {11'd0, status[1]}, 12'd0);
        step(1);
        chk("R8 after en rise", {11'd0, status[1]}, 12'd1);

        // R8 enable drop and comparator fall in the same cycle
        en[0] = 1'b0; uv[0] = 1'b0;
        step(2 + EN_FILT);
        chk("R8 same-cycle before", {11'd0, status[0]}, 12'd1);
        step(1);
        chk("R8 same-cycle after", {11'd0, status[0]}, 12'd0);
        en[0] = 1'b1; uv[0] = 1'b1;
        step(50);

        // R9 glitch rejection
        uv[2] = 1'b0;
        step(UV_FILT - 1);
        uv[2] = 1'b1;
        hold_chk("R9 short uv pulse", 2, 1'b1, 40);
        en[3] = 1'b0;
        step(EN_FILT - 1);
        en[3] = 1'b1;
        hold_chk("R9 short en pulse", 3, 1'b1, 30);
        uv[2] = 1'b0;
        step(UV_FILT);
        uv[2] = 1'b1;
        step(12);
        chk("R9 full-width pulse passes", {11'd0, status[2]}, 12'd0);
        step(50);

        // R10 release-delay programming
        write_dly(0, 8'd5);
        uv[0] = 1'b0;
        step(25);
        uv[0] = 1'b1;
        step(1 + UV_FILT + 5);
        chk("R10 short delay before", {11'd0, status[0]}, 12'd0);
        step(1);
        chk("R10 short delay after", {11'd0, status[0]}, 12'd1);
        write_dly(0, 8'd0);
        uv[0] = 1'b0;
        step(25);
        uv[0] = 1'b1;
        step(1 + UV_FILT + DLY_DEF);
        chk("R10 default before", {11'd0, status[0]}, 12'd0);
        step(1);
        chk("R10 default after", {11'd0, status[0]}, 12'd1);

        // R1 disabled channel ignores comparator
        en[3] = 1'b0;
        step(20);
        for (int i = 0; i < 6; i++) begin
            uv[3] = ~uv[3];
            step(15);
        end
        hold_chk("R1 disabled ignores input", 3, 1'b0, 20);

        // R3 / R4 / R5 paired mode
        en = 4'hF; uv = 4'hF; ov = 2'b00; mode = 1'b1;
        step(60);
        chk("R3 paired valid", {8'd0, status}, 12'h003);
        ov[0] = 1'b1;
        step(40);
        chk("R3 over-voltage clears out1", {8'd0, status}, 12'h002);
        ov[0] = 1'b0; en[3] = 1'b0;
        step(60);
        chk("R3 partner enable clears out2", {8'd0, status}, 12'h001);
        inv = 1'b1;
        step(10);
        chk("R5 paired inverted idle", {8'd0, status}, 12'h00D);
        mode = 1'b0; en = 4'hF;
        step(60);
        chk("R5 independent inverted", {8'd0, status}, 12'h003);
        inv = 1'b0;

        // R4 upper delays irrelevant in paired mode
        write_dly(2, 8'd200);
        mode = 1'b1;
        step(60);
        chk("R4 upper idle", {8'd0, status}, 12'h003);
        write_dly(2, 8'd0);

        // Random settled patterns for R2 R3 R4 R5
        for (int i = 0; i < 60; i++) begin
            en   = 4'($urandom_range(0, 15));
            uv   = 4'($urandom_range(0, 15));
            ov   = 2'($urandom_range(0, 3));
            mode = 1'($urandom_range(0, 1));
            inv  = 1'($urandom_range(0, 1));
            step(70);
            chk(mode ? "R3 random paired" : "R2 random independent",
                {8'd0, status}, {8'd0, exp_status(en, uv, ov, mode, inv)});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule